// File: doc/BRIEF.md
# Per-Block Write-Protect Lock Sequencer

This block holds a three-state write-protect record for each erase block of a flash array. Each record is unlocked, locked or lock-tight. A cold reset locks every block. Software writes a block range into two address registers and then issues one of four lock commands. The sequencer walks the range one block per clock, updates each record it may change, and mirrors the last written state into a status register.

The lock-tight state is sticky, and it is handled differently by different commands. Range unlock, range lock and unlock-all stop at the first lock-tight block. Lock-tight-range steps over unlocked blocks and continues. Writing the start address also copies it into the end address, so a single-block range takes one register write.

Program and erase logic elsewhere read the record of any block through a combinational query port. Completion of any command raises a sticky interrupt, which stays set until it is acknowledged.

Top module: `wp_lock_seq`

## Requirements
- R1: After a synchronous reset, every block reads locked, wp_status is 0x0002, both range registers are 0, and busy, done, cmd_err and int_pend are low.
- R2: Records are one-hot: 3'b001 lock-tight, 3'b010 locked, 3'b100 unlocked. q_state shows the stored record of block q_addr in the same cycle, and shows a new record from the clock edge that writes it.
- R3: A start write stores wr_data & (NUM_BLOCKS-1) into both unl_start and unl_end. An end write stores the masked value into unl_end only. A start write takes precedence when both arrive together.
- R4: Opcode 0x2A (lock range) and opcode 0x23 (unlock range) visit blocks unl_start..unl_end inclusive, in ascending order. Each visited block and wp_status take the new state. When unl_end < unl_start, no record and no status changes. wp_status changes only while a walk runs.
- R5: Range lock and range unlock stop at the first lock-tight block. That block and every later block in the range keep their records.
- R6: Opcode 0x2C (lock-tight range) steps over unlocked blocks without changing them and keeps going. Every other block in the range becomes lock-tight, and wp_status becomes 0x0001.
- R7: Opcode 0x27 (unlock all) visits blocks from 0 up to NUM_BLOCKS-1 and stops at the first lock-tight block.
- R8: One block is visited per clock. busy goes high on the edge that accepts a command. A walk of n blocks with no stop keeps busy high for n+1 cycles, and a walk that stops on a block keeps it high one cycle past the last visited block. done pulses for one cycle as busy falls. A command strobe while busy is ignored.
- R9: Each completion sets int_pend, which stays high until int_clr. int_clr clears both int_pend and cmd_err. A completion in the same cycle as int_clr wins.
- R10: Any other opcode starts no walk and leaves busy low. It sets cmd_err and int_pend and pulses done on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| wr_start | input | 1 | Write strobe for the range start register |
| wr_end | input | 1 | Write strobe for the range end register |
| wr_data | input | REG_W | Data for the range register writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| int_clr | input | 1 | Acknowledge; clears int_pend and cmd_err |
| q_addr | input | ADDR_W | Block index for the query port |
| q_state | output | 3 | Stored record of block q_addr |
| unl_start | output | ADDR_W | Range start register |
| unl_end | output | ADDR_W | Range end register |
| wp_status | output | REG_W | Write-protect status register |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Sticky command error |
| int_pend | output | 1 | Sticky completion interrupt |

## Verification
Unlock and lock walks run over an all-locked range and then over a range already seeded with lock-tight blocks. The two runs separate a correct stop from a walk that runs to the end of the range. Lock-tight runs over a range where unlocked blocks sit between locked ones, which tells skip-and-continue apart from stop or overwrite. Unlock-all runs once after a cold reset, crossing the whole array, and once against a lock-tight barrier. An inverted range, an undefined opcode and a command strobe during a walk check the paths that must leave the records alone.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

  typedef enum logic [2:0] {
    WP_TIGHT    = 3'b001,
    WP_LOCKED   = 3'b010,
    WP_UNLOCKED = 3'b100
  } wp_state_e;

  typedef enum logic [1:0] {
    K_UNLOCK = 2'd0,
    K_LOCK   = 2'd1,
    K_TIGHT  = 2'd2
  } walk_kind_e;

  localparam logic [7:0] OP_UNLOCK_RANGE = 8'h23;
  localparam logic [7:0] OP_UNLOCK_ALL   = 8'h27;
  localparam logic [7:0] OP_LOCK_RANGE   = 8'h2A;
  localparam logic [7:0] OP_TIGHT_RANGE  = 8'h2C;

  function automatic logic [2:0] kind_target(input walk_kind_e k);
    case (k)
      K_UNLOCK: kind_target = WP_UNLOCKED;
      K_LOCK:   kind_target = WP_LOCKED;
      default:  kind_target = WP_TIGHT;
    endcase
  endfunction

endpackage

// File: rtl/wp_state_mem.sv
module wp_state_mem #(
  parameter int NUM_BLOCKS = 16,
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [2:0]        wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [2:0]        rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [2:0]        rdata_b
);
  import wp_lock_pkg::*;

  logic [2:0] mem [NUM_BLOCKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BLOCKS; i++) mem[i] <= WP_LOCKED;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int NUM_BLOCKS = 16,
  parameter int REG_W = 16,
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic [REG_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q
);
  logic [ADDR_W-1:0] masked;
  assign masked = wr_data[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (wr_start) begin
      start_q <= masked;
      end_q   <= masked;
    end else if (wr_end) begin
      end_q   <= masked;
    end
  end

endmodule

// File: rtl/wp_walker.sv
module wp_walker #(
  parameter int NUM_BLOCKS = 16,
  parameter int REG_W = 16,
  localparam int ADDR_W = $clog2(NUM_BLOCKS),
  localparam int IDX_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              int_clr,
  input  logic [ADDR_W-1:0] start_q,
  input  logic [ADDR_W-1:0] end_q,
  input  logic [2:0]        cur_state,
  output logic [ADDR_W-1:0] cur_idx,
  output logic              mem_we,
  output logic [2:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              int_pend,
  output logic [REG_W-1:0]  wp_status
);
  import wp_lock_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);
  localparam logic [IDX_W-1:0] COUNT    = IDX_W'(NUM_BLOCKS);

  walk_kind_e       kind;
  logic [IDX_W-1:0] idx, lim;
  logic             at_end, oob, hit_tight, skip_blk;

  assign cur_idx   = idx[ADDR_W-1:0];
  assign at_end    = idx > lim;
  assign oob       = idx >= COUNT;
  assign hit_tight = (kind != K_TIGHT) && (cur_state == WP_TIGHT);
  assign skip_blk  = (kind == K_TIGHT) && (cur_state == WP_UNLOCKED);
  assign mem_wdata = kind_target(kind);
  assign mem_we    = busy && !at_end && !oob && !hit_tight && !skip_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      int_pend  <= 1'b0;
      wp_status <= REG_W'(WP_LOCKED);
      kind      <= K_UNLOCK;
      idx       <= '0;
      lim       <= '0;
    end else begin
      done <= 1'b0;
      if (int_clr) begin
        int_pend <= 1'b0;
        cmd_err  <= 1'b0;
      end
      if (!busy) begin
        if (cmd_valid) begin
          idx <= IDX_W'(start_q);
          lim <= IDX_W'(end_q);
          case (cmd_op)
            OP_UNLOCK_RANGE: begin kind <= K_UNLOCK; busy <= 1'b1; end
            OP_LOCK_RANGE:   begin kind <= K_LOCK;   busy <= 1'b1; end
            OP_TIGHT_RANGE:  begin kind <= K_TIGHT;  busy <= 1'b1; end
            OP_UNLOCK_ALL: begin
              kind <= K_UNLOCK;
              busy <= 1'b1;
              idx  <= '0;
              lim  <= LAST_IDX;
            end
            default: begin
              cmd_err  <= 1'b1;
              int_pend <= 1'b1;
              done     <= 1'b1;
            end
          endcase
        end
      end else begin
        if (at_end || hit_tight || oob) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          int_pend <= 1'b1;
          if (oob && !at_end) cmd_err <= 1'b1;
        end else begin
          if (mem_we) wp_status <= REG_W'(mem_wdata);
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wp_lock_seq.sv
module wp_lock_seq #(
  parameter int NUM_BLOCKS = 16,
  parameter int REG_W = 16,
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              int_clr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [2:0]        q_state,
  output logic [ADDR_W-1:0] unl_start,
  output logic [ADDR_W-1:0] unl_end,
  output logic [REG_W-1:0]  wp_status,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              int_pend
);
  logic [ADDR_W-1:0] walk_idx;
  logic [2:0]        walk_state, wr_state;
  logic              wr_en;

  wp_range_regs #(.NUM_BLOCKS(NUM_BLOCKS), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_end(wr_end),
    .wr_data(wr_data), .start_q(unl_start), .end_q(unl_end)
  );

  wp_state_mem #(.NUM_BLOCKS(NUM_BLOCKS)) u_mem (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(walk_idx), .wdata(wr_state),
    .raddr_a(walk_idx), .rdata_a(walk_state),
    .raddr_b(q_addr), .rdata_b(q_state)
  );

  wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .REG_W(REG_W)) u_walk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .int_clr(int_clr), .start_q(unl_start), .end_q(unl_end),
    .cur_state(walk_state), .cur_idx(walk_idx), .mem_we(wr_en),
    .mem_wdata(wr_state), .busy(busy), .done(done), .cmd_err(cmd_err),
    .int_pend(int_pend), .wp_status(wp_status)
  );

endmodule

// File: rtl/wp_lock_seq_chk.sv
module wp_lock_seq_chk #(
  parameter int NUM_BLOCKS = 16,
  parameter int REG_W = 16,
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_start,
  input logic [2:0]        q_state,
  input logic [ADDR_W-1:0] unl_start,
  input logic [ADDR_W-1:0] unl_end,
  input logic [REG_W-1:0]  wp_status,
  input logic              busy,
  input logic              done,
  input logic              cmd_err,
  input logic              int_pend
);
  AST_QUERY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(q_state) == 1); // R2
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ($countones(wp_status[2:0]) == 1) && (wp_status[REG_W-1:3] == '0)); // R2
  AST_END_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    $past(wr_start) |-> (unl_end == unl_start)); // R3
  AST_STATUS_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(wp_status)); // R4
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_SETS_INT: assert property (@(posedge clk) disable iff (rst)
    done |-> int_pend); // R9
  AST_ERR_WITH_INT: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> int_pend); // R10
endmodule

bind wp_lock_seq wp_lock_seq_chk #(.NUM_BLOCKS(NUM_BLOCKS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .wr_start(wr_start), .q_state(q_state),
  .unl_start(unl_start), .unl_end(unl_end), .wp_status(wp_status),
  .busy(busy), .done(done), .cmd_err(cmd_err), .int_pend(int_pend)
);

// File: tb/wp_lock_seq_tb.sv
module wp_lock_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst = 1'b1;
  logic wr_start = 0, wr_end = 0, cmd_valid = 0, int_clr = 0;
  logic [15:0] wr_data = '0;
  logic [7:0] cmd_op = '0;
  logic [AW-1:0] q_addr = '0;
  logic [2:0] q_state;
  logic [AW-1:0] unl_start, unl_end;
  logic [15:0] wp_status;
  logic busy, done, cmd_err, int_pend;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_lock_seq #(.NUM_BLOCKS(N), .REG_W(16)) u_dut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_end(wr_end),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .int_clr(int_clr), .q_addr(q_addr), .q_state(q_state),
    .unl_start(unl_start), .unl_end(unl_end), .wp_status(wp_status),
    .busy(busy), .done(done), .cmd_err(cmd_err), .int_pend(int_pend)
  );

  // Behavioural reference: a queue of pending block indices per command.
  int m_blk [N];
  int q_walk [$];
  int m_kind, m_start, m_end, m_status;
  bit m_busy, m_done, m_err, m_int, m_seen_rst;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_blk[i] = 2;
      q_walk.delete();
      m_start = 0; m_end = 0; m_status = 2;
      m_busy = 0; m_done = 0; m_err = 0; m_int = 0; m_kind = 0;
      m_seen_rst = 1;
    end else begin
      int tgt;
      m_done = 0;
      if (int_clr) begin m_int = 0; m_err = 0; end
      tgt = (m_kind == 0) ? 4 : (m_kind == 1) ? 2 : 1;
      if (m_busy) begin
        if (q_walk.size() == 0) begin
          m_busy = 0; m_done = 1; m_int = 1;
        end else begin
          int b;
          b = q_walk.pop_front();
          if (m_kind != 2 && m_blk[b] == 1) begin
            q_walk.delete(); m_busy = 0; m_done = 1; m_int = 1;
          end else if (!(m_kind == 2 && m_blk[b] == 4)) begin
            m_blk[b] = tgt; m_status = tgt;
          end
        end
      end else if (cmd_valid) begin
        if (cmd_op == 8'h23 || cmd_op == 8'h2A || cmd_op == 8'h2C) begin
          m_kind = (cmd_op == 8'h23) ? 0 : (cmd_op == 8'h2A) ? 1 : 2;
          for (int i = m_start; i <= m_end; i++) q_walk.push_back(i);
          m_busy = 1;
        end else if (cmd_op == 8'h27) begin
          m_kind = 0;
          for (int i = 0; i < N; i++) q_walk.push_back(i);
          m_busy = 1;
        end else begin
          m_err = 1; m_int = 1; m_done = 1;
        end
      end
      if (wr_start) begin
        m_start = int'(wr_data) % N; m_end = m_start;
      end else if (wr_end) begin
        m_end = int'(wr_data) % N;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_seen_rst && !rst && !finished) begin
      chk("R8 busy", busy, m_busy);
      chk("R8 done", done, m_done);
      chk("R10 cmd_err", cmd_err, m_err);
      chk("R9 int_pend", int_pend, m_int);
      chk("R4 wp_status", wp_status, m_status);
      chk("R3 unl_start", unl_start, m_start);
      chk("R3 unl_end", unl_end, m_end);
      chk("R2 q_state", q_state, m_blk[q_addr]);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0; tick();
  endtask

  task automatic set_start(input int v);
    wr_data = 16'(v); wr_start = 1; tick(); wr_start = 0;
  endtask

  task automatic set_end(input int v);
    wr_data = 16'(v); wr_end = 1; tick(); wr_end = 0;
  endtask

  task automatic run(input logic [7:0] op, output int ncyc);
    cmd_op = op; cmd_valid = 1; tick(); cmd_valid = 0;
    ncyc = 0;
    while (busy && ncyc < 1000) begin ncyc++; tick(); end
  endtask

  task automatic qchk(input string tag, input int a, input int exp);
    q_addr = AW'(a); #1;
    chk(tag, q_state, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R1 reset state
    chk("R1 status", wp_status, 2);
    chk("R1 busy", busy, 0);
    chk("R1 int", int_pend, 0);
    for (int i = 0; i < N; i++) qchk("R1 block locked", i, 2);

    // R3 start copies into end, end write alone
    set_start(16'h13);
    chk("R3 start masked", unl_start, 3);
    chk("R3 end copied", unl_end, 3);
    set_end(7);
    chk("R3 end only", unl_end, 7);
    chk("R3 start kept", unl_start, 3);

    // R4/R8 unlock range 3..7
    run(8'h23, n);
    chk("R8 busy cycles", n, 6);
    chk("R4 status unlocked", wp_status, 4);
    chk("R9 int after done", int_pend, 1);
    qchk("R4 block 3", 3, 4);
    qchk("R4 block 7", 7, 4);
    qchk("R4 block 2 untouched", 2, 2);
    qchk("R4 block 8 untouched", 8, 2);

    // R8 strobe during busy ignored
    cmd_op = 8'h2A; cmd_valid = 1; tick(); cmd_valid = 0;
    tick();
    cmd_op = 8'h27; cmd_valid = 1; tick(); cmd_valid = 0;
    while (busy) tick();
    tick();
    qchk("R8 ignored unlock-all", 0, 2);
    qchk("R4 lock range block 5", 5, 2);

    // R9 clear
    int_clr = 1; tick(); int_clr = 0;
    chk("R9 int cleared", int_pend, 0);

    run(8'h23, n);
    // R6 lock-tight 2..9 skipping unlocked 3..7
    set_start(2); set_end(9);
    run(8'h2C, n);
    chk("R6 busy cycles", n, 9);
    chk("R6 status tight", wp_status, 1);
    qchk("R6 block 2 tight", 2, 1);
    qchk("R6 block 4 skipped", 4, 4);
    qchk("R6 block 9 tight", 9, 1);

    // R5 unlock 0..15 stops at block 2
    set_start(0); set_end(15);
    run(8'h23, n);
    chk("R5 stop cycles", n, 3);
    qchk("R5 block 1 unlocked", 1, 4);
    qchk("R5 block 2 still tight", 2, 1);
    qchk("R5 block 10 untouched", 10, 2);

    // R7 unlock-all stops at tight block 2
    set_start(3); set_end(5);
    run(8'h2A, n);
    run(8'h27, n);
    chk("R7 stop cycles", n, 3);
    qchk("R7 block 3 stays locked", 3, 2);

    // R4 inverted range
    set_start(9); set_end(4);
    run(8'h2A, n);
    chk("R4 empty range cycles", n, 1);
    chk("R4 empty range status", wp_status, 4);
    qchk("R4 empty range block 9", 9, 1);

    // R10 undefined opcode
    int_clr = 1; tick(); int_clr = 0;
    cmd_op = 8'h71; cmd_valid = 1; tick(); cmd_valid = 0;
    chk("R10 busy low", busy, 0);
    chk("R10 done", done, 1);
    chk("R10 err", cmd_err, 1);
    chk("R10 int", int_pend, 1);
    tick();
    int_clr = 1; tick(); int_clr = 0;
    chk("R9 err cleared", cmd_err, 0);

    set_start(16'h1F5);
    chk("R3 mask start", unl_start, 5);

    // R7 full unlock-all after cold reset
    do_reset();
    qchk("R1 block 15 locked", 15, 2);
    run(8'h27, n);
    chk("R7 full cycles", n, 17);
    qchk("R7 block 0", 0, 4);
    qchk("R7 block 15", 15, 4);
    tick(); tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule